// File: doc/BRIEF.md
# Shared Disk-Bus Enable Sequencer

This block watches an external enable strap that lets a bridge hand its disk-side parallel bus over to other hosts. The strap is read only on a slow periodic poll, after a two-stage synchronizer. Each accepted sample decides whether the bus pins are driven or released. A released bus also holds the bus protocol engine halted.

A change between two successive samples also moves the power state, and the move depends on where the chip is:
- **Running:** a falling enable detaches the chip from USB and enters low power.
- **Disabled low power:** a high enable re-attaches the chip and emits a one-cycle re-initialise pulse, unless another low-power cause is active.
- **USB suspend:** any enable change wakes the chip for a fixed number of cycles. The new bus drive state is applied on the first of those cycles, and the chip then drops back to low power.

A manufacturing-mode strap stops the poll and forces the bus driven and the chip attached. All pins are plain level controls. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_share_sequencer`

## Requirements
- R1: During and after reset, before the first poll sample, bus_oe_o is 0, bus_halt_o is 1, usb_attach_o is 1, low_power_o is 0 and reinit_pulse_o is 0.
- R2: share_en_i passes through two synchronizer flops and is sampled only on poll ticks. The first tick is on the POLL_CYCLES-th clock edge after reset, and later ticks follow every POLL_CYCLES edges. A change that is undone between two ticks has no effect on any output.
- R3: After each tick, bus_oe_o equals the sampled enable and bus_halt_o is its inverse. The change appears on the edge that takes the sample.
- R4: In the running state, a sample of 0 following a sample of 1 clears usb_attach_o, sets low_power_o and releases the bus, all on the same edge.
- R5: In the disabled low-power state, a tick that samples 1 while other_lp_i is 0 sets usb_attach_o, clears low_power_o and pulses reinit_pulse_o. If other_lp_i is 1, the chip stays detached and in low power, but the bus becomes driven.
- R6: In the running state, usb_suspend_i at 1 sets low_power_o on the next edge while usb_attach_o stays 1. When usb_suspend_i returns to 0 in the suspended state, low_power_o clears on the next edge.
- R7: In the suspended state, a tick whose sample differs from the previous one clears low_power_o for exactly WAKE_CYCLES cycles. The new bus drive state appears on the first of those cycles, and usb_attach_o stays 1.
- R8: In the suspended state, a tick whose sample equals the previous one leaves low_power_o at 1.
- R9: While mfg_mode_i is 1:
  - bus_oe_o is 1, usb_attach_o is 1 and low_power_o is 0.
  - No poll sample is taken, and the chip returns to the running state.
  - After mfg_mode_i falls, the next tick comes POLL_CYCLES edges later.
- R10: reinit_pulse_o lasts exactly one cycle and occurs only when the chip leaves the disabled low-power state.
- R11: When a falling sample and a USB suspend request meet in the running state on the same edge, the falling sample wins and the chip detaches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| share_en_i | input | 1 | Asynchronous bus-share enable strap, high to own the bus |
| mfg_mode_i | input | 1 | Manufacturing-mode strap |
| usb_suspend_i | input | 1 | USB suspend request |
| other_lp_i | input | 1 | Another low-power cause is active |
| bus_oe_o | output | 1 | Bus pin output enable, 0 releases the pins |
| bus_halt_o | output | 1 | Holds the bus protocol engine halted |
| usb_attach_o | output | 1 | USB attach (pull-up connect) |
| low_power_o | output | 1 | Chip in low-power state |
| reinit_pulse_o | output | 1 | One-cycle return-to-post-reset pulse |

## Verification
The bound checker watches four things on every cycle:
- the re-initialise pulse is a single cycle and follows a detached cycle;
- a detach always comes with low power and a released bus;
- the bus drive outside manufacturing mode moves only right after a poll tick;
- manufacturing mode forces its outputs.

Only the bench scenarios can show the poll timing. That covers the first sample landing on the POLL_CYCLES-th edge, glitches between ticks being ignored, the exact length of a suspended wake, the precedence of a fall over a suspend request, and the restart of the poll count after manufacturing mode.

// File: rtl/bse_pkg.sv
package bse_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_SUSP = 2'd1,
    PS_WAKE = 2'd2,
    PS_OFF  = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/bse_sync.sv
module bse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bse_poll_timer.sv
module bse_poll_timer #(
  parameter int POLL_CYCLES = 480000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic tick_o
);

  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (hold_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = !hold_i && (cnt_q == LAST);

endmodule

// File: rtl/bse_power_fsm.sv
module bse_power_fsm
  import bse_pkg::*;
#(
  parameter int WAKE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_s_i,
  input  logic       mfg_i,
  input  logic       usb_suspend_i,
  input  logic       other_lp_i,
  output logic       drive_o,
  output pwr_state_e state_o,
  output logic       reinit_o
);

  localparam int WW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYCLES - 1);

  pwr_state_e st_q, st_d;
  logic       samp_q, seen_q;
  logic       reinit_q, reinit_d;
  logic [WW-1:0] wcnt_q;
  logic       rise, fall;

  assign rise = tick_i && seen_q && !samp_q &&  en_s_i;
  assign fall = tick_i && seen_q &&  samp_q && !en_s_i;

  always_comb begin
    st_d     = st_q;
    reinit_d = 1'b0;
    case (st_q)
      PS_RUN: begin
        if (fall)               st_d = PS_OFF;
        else if (usb_suspend_i) st_d = PS_SUSP;
      end
      PS_SUSP: begin
        if (rise || fall)        st_d = PS_WAKE;
        else if (!usb_suspend_i) st_d = PS_RUN;
      end
      PS_WAKE: begin
        if (wcnt_q == WLAST) st_d = PS_SUSP;
      end
      PS_OFF: begin
        if (tick_i && en_s_i && !other_lp_i) begin
          st_d     = PS_RUN;
          reinit_d = 1'b1;
        end
      end
      default: st_d = PS_RUN;
    endcase
    if (mfg_i) begin
      st_d     = PS_RUN;
      reinit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_RUN;
      reinit_q <= 1'b0;
      wcnt_q   <= '0;
      samp_q   <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      reinit_q <= reinit_d;
      wcnt_q   <= (st_q == PS_WAKE) ? wcnt_q + WW'(1) : '0;
      if (tick_i) begin
        samp_q <= en_s_i;
        seen_q <= 1'b1;
      end
    end
  end

  assign drive_o  = samp_q;
  assign state_o  = st_q;
  assign reinit_o = reinit_q;

endmodule

// File: rtl/bus_share_sequencer.sv
module bus_share_sequencer
  import bse_pkg::*;
#(
  parameter int POLL_CYCLES = 480000,
  parameter int WAKE_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic share_en_i,
  input  logic mfg_mode_i,
  input  logic usb_suspend_i,
  input  logic other_lp_i,
  output logic bus_oe_o,
  output logic bus_halt_o,
  output logic usb_attach_o,
  output logic low_power_o,
  output logic reinit_pulse_o
);

  logic       en_sync;
  logic       poll_tick;
  logic       drive;
  logic       reinit;
  pwr_state_e pstate;

  bse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (share_en_i),
    .q_o   (en_sync)
  );

  bse_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (mfg_mode_i),
    .tick_o (poll_tick)
  );

  bse_power_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (poll_tick),
    .en_s_i        (en_sync),
    .mfg_i         (mfg_mode_i),
    .usb_suspend_i (usb_suspend_i),
    .other_lp_i    (other_lp_i),
    .drive_o       (drive),
    .state_o       (pstate),
    .reinit_o      (reinit)
  );

  assign bus_oe_o       = mfg_mode_i | drive;
  assign bus_halt_o     = ~bus_oe_o;
  assign usb_attach_o   = mfg_mode_i | (pstate != PS_OFF);
  assign low_power_o    = ~mfg_mode_i & ((pstate == PS_SUSP) || (pstate == PS_OFF));
  assign reinit_pulse_o = reinit;

endmodule

// File: rtl/bse_checker.sv
module bse_checker (
  input logic clk,
  input logic rst_n,
  input logic mfg_mode_i,
  input logic poll_tick,
  input logic bus_oe_o,
  input logic usb_attach_o,
  input logic low_power_o,
  input logic reinit_pulse_o
);

  // R10
  reinit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse_o |=> !reinit_pulse_o);

  // R5
  reinit_attach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse_o |-> (usb_attach_o && !low_power_o && !$past(usb_attach_o)));

  // R4
  detach_lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usb_attach_o) |-> (low_power_o && !bus_oe_o));

  // R2
  drive_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bus_oe_o) && !mfg_mode_i && !$past(mfg_mode_i)) |-> $past(poll_tick));

  // R9
  mfg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfg_mode_i |-> (bus_oe_o && usb_attach_o && !low_power_o));

endmodule

bind bus_share_sequencer bse_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mfg_mode_i     (mfg_mode_i),
  .poll_tick      (poll_tick),
  .bus_oe_o       (bus_oe_o),
  .usb_attach_o   (usb_attach_o),
  .low_power_o    (low_power_o),
  .reinit_pulse_o (reinit_pulse_o)
);

// File: tb/tb_bus_share_sequencer.sv
`timescale 1ns/1ps
module tb_bus_share_sequencer;

  localparam int POLL = 40;
  localparam int WAKE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, mfg = 1'b0, susp = 1'b0, olp = 1'b0;
  logic bus_oe, bus_halt, attach, lowp, reinit;

  int n_tests = 0;
  int n_fail  = 0;
  int ph = 0;
  logic last_tick = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_share_sequencer #(.POLL_CYCLES(POLL), .WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .share_en_i(en), .mfg_mode_i(mfg),
    .usb_suspend_i(susp), .other_lp_i(olp), .bus_oe_o(bus_oe),
    .bus_halt_o(bus_halt), .usb_attach_o(attach), .low_power_o(lowp),
    .reinit_pulse_o(reinit)
  );

  // Poll phase derived from R2 and R9: tick every POLL edges, reset by manufacturing mode
  always @(posedge clk) begin
    if (!rst_n || mfg) begin
      ph <= 0;
      last_tick <= 1'b0;
    end else begin
      last_tick <= (ph == POLL - 1);
      ph <= (ph == POLL - 1) ? 0 : ph + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int oe, input int att, input int lp, input int rp);
    check(req, "bus_oe", bus_oe, oe);
    check(req, "bus_halt", bus_halt, 1 - oe);
    check(req, "attach", attach, att);
    check(req, "low_power", lowp, lp);
    check(req, "reinit", reinit, rp);
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_tick();
    do @(negedge clk); while (!last_tick);
  endtask

  task automatic to_pre_tick();
    while (ph != POLL - 1) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit exp_off, exp_drv, exp_rp;

    adv(3);
    outs("R1", 0, 1, 0, 0);
    rst_n = 1'b1;
    adv(1);
    outs("R1", 0, 1, 0, 0);

    // R2: no sample before the POLL-th edge; R3: drive after it
    en = 1'b1;
    to_pre_tick();
    check("R2", "bus_oe before first tick", bus_oe, 0);
    adv(1);
    outs("R3", 1, 1, 0, 0);

    // R2: glitch between ticks is ignored
    adv(5); en = 1'b0; adv(5); en = 1'b1;
    to_tick();
    outs("R2", 1, 1, 0, 0);

    // R4: falling sample in run
    adv(3); en = 1'b0;
    to_tick();
    outs("R4", 0, 0, 1, 0);

    // R5: blocked by other low-power cause
    olp = 1'b1; en = 1'b1;
    to_tick();
    outs("R5", 1, 0, 1, 0);
    olp = 1'b0;
    to_tick();
    outs("R5", 1, 1, 0, 1);
    adv(1);
    check("R10", "reinit width", reinit, 0);

    // R6: suspend
    susp = 1'b1;
    adv(1);
    outs("R6", 1, 1, 1, 0);

    // R8: unchanged sample while suspended
    to_tick();
    outs("R8", 1, 1, 1, 0);

    // R7: brief wake on fall then on rise
    adv(2); en = 1'b0;
    to_tick();
    outs("R7", 0, 1, 0, 0);
    adv(WAKE - 1);
    check("R7", "low_power last wake cycle", lowp, 0);
    adv(1);
    outs("R7", 0, 1, 1, 0);
    en = 1'b1;
    to_tick();
    outs("R7", 1, 1, 0, 0);
    adv(WAKE);
    outs("R7", 1, 1, 1, 0);

    // R6: suspend released
    susp = 1'b0;
    adv(1);
    outs("R6", 1, 1, 0, 0);

    // R11: fall and suspend on the same edge
    adv(2); en = 1'b0;
    to_pre_tick();
    susp = 1'b1;
    adv(1);
    outs("R11", 0, 0, 1, 0);
    susp = 1'b0;

    // R3 R4 R5: sweep every enable sequence of four samples
    exp_off = 1'b1; exp_drv = 1'b0;
    for (int v = 0; v < 16; v++) begin
      for (int b = 0; b < 4; b++) begin
        en = v[b];
        to_tick();
        exp_rp = 1'b0;
        if (exp_off && en) begin
          exp_off = 1'b0;
          exp_rp = 1'b1;
        end else if (!exp_off && exp_drv && !en) begin
          exp_off = 1'b1;
        end
        exp_drv = en;
        outs("R3_R4_R5 sweep", exp_drv, !exp_off, exp_off, exp_rp);
      end
    end

    // R9: manufacturing mode
    en = 1'b0;
    to_tick();
    mfg = 1'b1; en = 1'b1;
    adv(1);
    outs("R9", 1, 1, 0, 0);
    adv(3 * POLL);
    outs("R9", 1, 1, 0, 0);
    mfg = 1'b0;
    adv(POLL - 1);
    outs("R9", 0, 1, 0, 0);
    adv(1);
    outs("R9", 1, 1, 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule